// File: doc/BRIEF.md
# Parallel Command/Data Bus Slave

This block sits on the programmable-logic side of a synchronous byte-wide link driven by a microcontroller. Every rising edge of the bus clock on which `bus_en` is high is one transfer. A select line (`bus_cmd`) says whether the byte is a command or data, and a direction line (`bus_wr`) says whether the host writes or reads. Data transfers go to a byte-wide memory port at the address held in an internal pointer. The pointer steps forward by one after each data access.

Command bytes form a small set. One code clears the slave. One code starts an address load, in which the next data writes supply the new pointer with the least significant byte first. A range of further codes fires single-cycle action strobes. All other codes are dropped. The slave drives the shared data lines only during a data read. `bus_doe` is intended as the enable of an external tristate buffer.

The control is a two-state machine. **ST_READY** is the normal state, in which data transfers reach the memory port. **ST_ADDR** collects address bytes. Its transitions are:
- *T_LOAD_START*: ST_READY to ST_ADDR, on the set-address command.
- *T_LOAD_RESTART*: ST_ADDR to ST_ADDR, on the set-address command; the byte count starts over.
- *T_LOAD_DONE*: ST_ADDR to ST_READY, on the last address byte; the pointer is loaded.
- *T_CLEAR*: ST_ADDR to ST_READY, on the clear command.
- *T_HOLD*: each state to itself, on any other cycle.

Top module: `pbus_slave`

## Requirements
- R1: In ST_READY, an edge with `bus_en`=1, `bus_cmd`=0 and `bus_wr`=1 asserts `mem_we` in that cycle, with `mem_wdata` equal to `bus_din` and `mem_addr` equal to the pointer.
- R2: An edge with `bus_en`=1, `bus_cmd`=0 and `bus_wr`=0 is a data read. In that same cycle `bus_doe` and `mem_re` are 1 and `bus_dout` equals `mem_rdata`.
- R3: `bus_doe` is 0 in every cycle that is not a data read: idle cycles, data writes, command writes and command reads.
- R4: The pointer (`mem_addr`) advances by one after each data read or data write in ST_READY. It wraps from all-ones to zero and is unchanged across cycles with `bus_en`=0.
- R5: The command byte 0x01 enters ST_ADDR. The next `ADDR_BYTES` data writes are assembled least significant byte first and load the pointer after the last one. These writes do not assert `mem_we`.
- R6: The command byte 0x00 sets the pointer to zero and returns to ST_READY, dropping any partial address. It produces no strobe.
- R7: A command byte from 0x02 to 0x01+`NUM_ACTIONS` raises `act_stb` for the single cycle that follows its edge, with `act_code` equal to the byte.
- R8: A command byte above 0x01+`NUM_ACTIONS`, and any command read, is ignored. It produces no strobe, leaves the pointer unchanged and does not disturb an address load in progress.
- R9: A partial address never changes the pointer. Issuing 0x01 again during ST_ADDR restarts the byte count.
- R10: A data read during ST_ADDR drives `bus_dout` from the current pointer. It does not advance the pointer and does not count as an address byte.
- R11: While `rst_n` is low the pointer is zero, the state is ST_READY and `act_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; transfers complete on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Transfer qualifier for this edge |
| bus_cmd | input | 1 | 1 = command byte, 0 = data byte |
| bus_wr | input | 1 | 1 = host writes, 0 = host reads |
| bus_din | input | 8 | Byte from the host |
| bus_dout | output | 8 | Byte to the host during a data read |
| bus_doe | output | 1 | Enable for the external data-line driver |
| mem_addr | output | 8*ADDR_BYTES | Current pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, combinational from `mem_addr` |
| act_stb | output | 1 | Single-cycle action strobe |
| act_code | output | 8 | Code of the last action command |

## Verification
The bench builds the slave with `ADDR_BYTES`=2 and `NUM_ACTIONS`=3. The 16-bit pointer can then be loaded to 0xFFFF and wrapped with a single write. The highest valid action code, 0x04, sits directly below the first ignored code, 0x05, so both sides of the decode boundary are checked. A two-byte address also keeps the abort, restart and partial-load cases short enough to test each one by itself.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_ADDR  = 1'b1
    } pbs_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_CLEAR,
        CMD_SETADDR,
        CMD_ACTION
    } pbs_cmd_e;

    localparam logic [7:0] OP_CLEAR   = 8'h00;
    localparam logic [7:0] OP_SETADDR = 8'h01;

endpackage

// File: rtl/pbs_cmd_decode.sv
module pbs_cmd_decode
    import pbs_pkg::*;
#(
    parameter int NUM_ACTIONS = 4
) (
    input  logic       valid,
    input  logic [7:0] code,
    output pbs_cmd_e   kind
);
    localparam int LAST_CODE = 1 + NUM_ACTIONS;

    always_comb begin
        kind = CMD_NONE;
        if (valid) begin
            if (code == OP_CLEAR)
                kind = CMD_CLEAR;
            else if (code == OP_SETADDR)
                kind = CMD_SETADDR;
            else if (int'(code) <= LAST_CODE)
                kind = CMD_ACTION;
        end
    end
endmodule

// File: rtl/pbs_addr_collect.sv
module pbs_addr_collect #(
    parameter int ADDR_BYTES = 4,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int CW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          take,
    input  logic [7:0]    byte_in,
    output logic          last,
    output logic [AW-1:0] full_addr
);
    logic [CW-1:0] idx;

    assign last = take && (idx == CW'(ADDR_BYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (restart)
            idx <= '0;
        else if (take)
            idx <= last ? '0 : idx + 1'b1;
    end

    // Lower byte lanes are held in registers; the top lane is the byte arriving now.
    for (genvar g = 0; g < ADDR_BYTES - 1; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (take && idx == CW'(g))
                lane_q <= byte_in;
        end
        assign full_addr[8*g +: 8] = lane_q;
    end
    assign full_addr[AW-1 -: 8] = byte_in;
endmodule

// File: rtl/pbs_ptr.sv
module pbs_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (clear)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbs_pkg::*;
#(
    parameter int ADDR_BYTES  = 4,
    parameter int NUM_ACTIONS = 4,
    localparam int AW = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_cmd,
    input  logic          bus_wr,
    input  logic [7:0]    bus_din,
    output logic [7:0]    bus_dout,
    output logic          bus_doe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          act_stb,
    output logic [7:0]    act_code
);
    pbs_state_e    state, nxt;
    pbs_cmd_e      kind;
    logic          cmd_write, data_write, data_read;
    logic          take, last_byte, ptr_inc, ptr_clear;
    logic [AW-1:0] new_addr;

    assign cmd_write  = bus_en &  bus_cmd &  bus_wr;
    assign data_write = bus_en & ~bus_cmd &  bus_wr;
    assign data_read  = bus_en & ~bus_cmd & ~bus_wr;

    pbs_cmd_decode #(.NUM_ACTIONS(NUM_ACTIONS)) u_dec (
        .valid (cmd_write),
        .code  (bus_din),
        .kind  (kind)
    );

    pbs_addr_collect #(.ADDR_BYTES(ADDR_BYTES)) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   ((kind == CMD_SETADDR) || (kind == CMD_CLEAR)),
        .take      (take),
        .byte_in   (bus_din),
        .last      (last_byte),
        .full_addr (new_addr)
    );

    pbs_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ptr_clear),
        .load     (last_byte),
        .load_val (new_addr),
        .inc      (ptr_inc),
        .ptr      (mem_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_READY;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY: begin
                if (kind == CMD_SETADDR)
                    nxt = ST_ADDR;              // T_LOAD_START
            end
            ST_ADDR: begin
                if (kind == CMD_CLEAR)
                    nxt = ST_READY;             // T_CLEAR
                else if (last_byte)
                    nxt = ST_READY;             // T_LOAD_DONE
                // T_LOAD_RESTART and T_HOLD keep ST_ADDR
            end
        endcase
    end

    // Per-cycle outputs and controls
    always_comb begin
        mem_we    = data_write && (state == ST_READY);
        mem_re    = data_read;
        mem_wdata = bus_din;
        bus_doe   = data_read;
        bus_dout  = mem_rdata;
        take      = data_write && (state == ST_ADDR);
        ptr_inc   = (data_write || data_read) && (state == ST_READY);
        ptr_clear = (kind == CMD_CLEAR);
    end

    // Registered action strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_stb  <= 1'b0;
            act_code <= '0;
        end else begin
            act_stb <= (kind == CMD_ACTION);
            if (kind == CMD_ACTION)
                act_code <= bus_din;
        end
    end
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
    parameter int AW          = 32,
    parameter int NUM_ACTIONS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_cmd,
    input logic          bus_wr,
    input logic [7:0]    bus_din,
    input logic          bus_doe,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          act_stb,
    input logic [7:0]    act_code
);
    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R1

    AST_DOE_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !bus_doe); // R3

    AST_DOE_NOT_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_cmd) |-> !bus_doe); // R3

    AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(mem_addr)); // R4

    AST_CLEAR_ZEROES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_cmd && bus_wr && bus_din == 8'h00) |=> (mem_addr == '0 && !act_stb)); // R6

    AST_STB_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> $past(bus_en && bus_cmd && bus_wr)); // R7

    AST_STB_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> (act_code >= 8'd2 && int'(act_code) <= NUM_ACTIONS + 1)); // R8
endmodule

bind pbus_slave pbus_slave_chk #(.AW(AW), .NUM_ACTIONS(NUM_ACTIONS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_cmd  (bus_cmd),
    .bus_wr   (bus_wr),
    .bus_din  (bus_din),
    .bus_doe  (bus_doe),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .act_stb  (act_stb),
    .act_code (act_code)
);

// File: tb/pbus_slave_test.sv
module pbus_slave_test;
    localparam int AB = 2;
    localparam int NA = 3;
    localparam int AW = 8 * AB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_cmd = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_din = '0;
    logic [7:0]    bus_dout;
    logic          bus_doe;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          act_stb;
    logic [7:0]    act_code;

    logic [7:0] mem [0:255];
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pbus_slave #(.ADDR_BYTES(AB), .NUM_ACTIONS(NA)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_cmd(bus_cmd), .bus_wr(bus_wr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .act_stb(act_stb), .act_code(act_code)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one bus cycle; returns shortly after the falling edge, before the sampling edge.
    task automatic cyc(input logic en, input logic cmd, input logic wr, input logic [7:0] d);
        @(negedge clk);
        bus_en = en; bus_cmd = cmd; bus_wr = wr; bus_din = d;
        #1;
    endtask

    task automatic idle();   cyc(1'b0, 1'b0, 1'b0, 8'h00); endtask
    task automatic cmd(input logic [7:0] c); cyc(1'b1, 1'b1, 1'b1, c); endtask
    task automatic wr(input logic [7:0] d);  cyc(1'b1, 1'b0, 1'b1, d); endtask
    task automatic rd();     cyc(1'b1, 1'b0, 1'b0, 8'h00); endtask

    task automatic set_addr(input logic [15:0] a);
        cmd(8'h01); wr(a[7:0]); wr(a[15:8]); idle();
    endtask

    task automatic t_reset();
        chk("R11 ptr", 32'(mem_addr), 32'h0);
        chk("R11 stb", 32'(act_stb), 32'h0);
        chk("R3 doe idle", 32'(bus_doe), 32'h0);
    endtask

    task automatic t_setaddr();
        cmd(8'h01); chk("R3 doe on cmd", 32'(bus_doe), 32'h0);
        wr(8'h34);  chk("R5 no we", 32'(mem_we), 32'h0);
        wr(8'h12);  chk("R5 no we", 32'(mem_we), 32'h0);
                    chk("R5 ptr not yet", 32'(mem_addr), 32'h0);
        idle();     chk("R5 loaded", 32'(mem_addr), 32'h1234);
    endtask

    task automatic t_write();
        set_addr(16'h0010);
        wr(8'hAA); chk("R1 we", 32'(mem_we), 32'h1); chk("R1 addr", 32'(mem_addr), 32'h10);
                   chk("R1 wdata", 32'(mem_wdata), 32'hAA); chk("R3 doe on write", 32'(bus_doe), 32'h0);
        wr(8'hBB); chk("R1 addr", 32'(mem_addr), 32'h11);
        wr(8'hCC); chk("R1 addr", 32'(mem_addr), 32'h12);
        idle();    chk("R4 advanced", 32'(mem_addr), 32'h13);
        idle();    chk("R4 idle hold", 32'(mem_addr), 32'h13);
        chk("R1 stored", 32'(mem[8'h11]), 32'hBB);
    endtask

    task automatic t_read();
        set_addr(16'h0010);
        rd(); chk("R2 doe", 32'(bus_doe), 32'h1); chk("R2 re", 32'(mem_re), 32'h1);
              chk("R2 dout", 32'(bus_dout), 32'hAA);
        rd(); chk("R2 dout", 32'(bus_dout), 32'hBB);
        rd(); chk("R2 dout", 32'(bus_dout), 32'hCC);
        idle(); chk("R4 read advance", 32'(mem_addr), 32'h13);
        cyc(1'b1, 1'b1, 1'b0, 8'h03); chk("R3 doe cmd read", 32'(bus_doe), 32'h0);
        idle(); chk("R8 cmd read no stb", 32'(act_stb), 32'h0);
                chk("R8 cmd read ptr", 32'(mem_addr), 32'h13);
    endtask

    task automatic t_action();
        cmd(8'h03); idle();
        chk("R7 stb", 32'(act_stb), 32'h1); chk("R7 code", 32'(act_code), 32'h03);
        idle(); chk("R7 one cycle", 32'(act_stb), 32'h0);
        cmd(8'h04); idle();
        chk("R7 top code stb", 32'(act_stb), 32'h1); chk("R7 top code", 32'(act_code), 32'h04);
    endtask

    task automatic t_unknown();
        set_addr(16'h0020);
        cmd(8'h05); idle(); chk("R8 0x05 no stb", 32'(act_stb), 32'h0);
        cmd(8'hFF); idle(); chk("R8 0xFF no stb", 32'(act_stb), 32'h0);
        chk("R8 ptr kept", 32'(mem_addr), 32'h20);
        cmd(8'h01); wr(8'h22); cmd(8'h7E); cmd(8'h02);
        idle(); chk("R8 action during load", 32'(act_stb), 32'h1);
        wr(8'h00); chk("R8 load continues", 32'(mem_we), 32'h0);
        idle(); chk("R8 load completes", 32'(mem_addr), 32'h0022);
    endtask

    task automatic t_abort();
        cmd(8'h01); wr(8'h77); cmd(8'h01); wr(8'h40); wr(8'h00);
        idle(); chk("R9 restart", 32'(mem_addr), 32'h0040);
        cmd(8'h01); wr(8'h55); idle(); idle();
        chk("R9 partial kept", 32'(mem_addr), 32'h0040);
        cmd(8'h00); idle(); chk("R6 cleared", 32'(mem_addr), 32'h0);
        chk("R6 no stb", 32'(act_stb), 32'h0);
        wr(8'h99); chk("R6 ready after clear", 32'(mem_we), 32'h1);
        idle(); chk("R6 stored at 0", 32'(mem[8'h00]), 32'h99);
    endtask

    task automatic t_read_in_load();
        set_addr(16'h0010);
        cmd(8'h01);
        rd(); chk("R10 doe", 32'(bus_doe), 32'h1); chk("R10 dout", 32'(bus_dout), 32'hAA);
        wr(8'h11); wr(8'h00);
        idle(); chk("R10 not counted", 32'(mem_addr), 32'h0011);
    endtask

    task automatic t_wrap();
        set_addr(16'hFFFF);
        wr(8'h5A); chk("R4 top addr", 32'(mem_addr), 32'hFFFF);
        idle(); chk("R4 wrap", 32'(mem_addr), 32'h0);
    endtask

    task automatic t_async_reset();
        set_addr(16'h0033);
        cmd(8'h02);
        @(negedge clk); bus_en = 1'b0; rst_n = 1'b0; #1;
        chk("R11 async ptr", 32'(mem_addr), 32'h0);
        chk("R11 async stb", 32'(act_stb), 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle();
        t_setaddr();
        t_write();
        t_read();
        t_action();
        t_unknown();
        t_abort();
        t_read_in_load();
        t_wrap();
        t_async_reset();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule